// File: doc/BRIEF.md
# Keyboard Repeat-Inhibit Configuration Sequencer

This block brings a serially attached keyboard into a known state after power-up and then acts as the path for its scan codes. It first pulses the keyboard's active-low reset line. It then discards any stale bytes waiting in the receive stream. Next it issues a two-byte command that turns off auto-repeat.

The keyboard expects a handshake line to be raised and held before each command byte, and lowered once the byte has gone out. Every byte must be answered with an acknowledge. A wrong answer makes the sequencer start the command pair again from the first byte. Once both bytes are acknowledged, the block raises a done flag and forwards each received byte as a scan code, with a press/release indication.

A reinitialisation code from the keyboard causes the whole configuration to run again. The byte transmitter and the byte receiver sit outside the block and use valid/ready streams. Every delay is derived from a ticks-per-microsecond parameter, so all timing scales with the clock.

Top module: `kbd_init_seq`

## Requirements
- R1: After reset, `kbd_rst_n` is low for RST_LOW_US×TICKS_PER_US cycles, then high. It then stays high for RST_SETTLE_US×TICKS_PER_US cycles before the receive stream is serviced. No command byte is offered while `kbd_rst_n` is low.
- R2: Before each configuration run, every pending receive byte is accepted and discarded without any scan output. The run proceeds once `rx_valid` is low.
- R3: The command pair is the byte 0x9C followed by the byte 0x70.
- R4: `kbd_rdy` is high while a command byte is offered. It is held high for HOLD1_US×TICKS_PER_US cycles before 0x9C is offered (counted from its rise on a retry). It is held high for HOLD2_US×TICKS_PER_US cycles before 0x70 is offered.
- R5: Once a command byte is accepted, `kbd_rdy` goes low. No response byte is accepted (`rx_ready` low) for POST_US×TICKS_PER_US cycles. After that the block waits with no time limit for the response.
- R6: A response other than 0xFA to either command byte restarts the pair from 0x9C, with the full first hold and no drain step.
- R7: `cfg_done` is low from reset until 0xFA has been received for 0x70. `scan_valid` is never high while `cfg_done` is low.
- R8: While configured, each accepted byte other than 0x60 appears on `scan_code` with `scan_valid` high for one cycle, one cycle after acceptance. `scan_release` equals bit 7 of the byte: 1 means key released, 0 means key pressed.
- R9: While configured, a received 0x60 is not forwarded. It clears `cfg_done` and reruns the configuration, starting with the drain step.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | output | 1 | Command byte offered to the byte transmitter |
| tx_data | output | 8 | Command byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| rx_valid | input | 1 | Receiver holds a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts the received byte this cycle |
| kbd_rdy | output | 1 | Handshake line to the keyboard |
| kbd_rst_n | output | 1 | Active-low keyboard reset line |
| cfg_done | output | 1 | Configuration finished |
| scan_valid | output | 1 | One-cycle strobe for a forwarded scan code |
| scan_code | output | 8 | Forwarded scan code |
| scan_release | output | 1 | 1 = key released, 0 = key pressed |

## Verification
The assertions assume that the receiver holds `rx_valid` and `rx_data` steady until `rx_ready` takes the byte. The forwarding and rerun checks compare the byte seen at acceptance with what comes out one cycle later. The bench drives its keyboard model only on falling edges. It raises a byte and holds it until it observes `rx_ready` high. It also delays `tx_ready` on some command bytes, which exercises the hold rule without ever withdrawing a byte.

// File: rtl/kbd_seq_pkg.sv
package kbd_seq_pkg;

  localparam logic [7:0] CMD_INHIBIT = 8'h9C;
  localparam logic [7:0] ARG_INHIBIT = 8'h70;
  localparam logic [7:0] KBD_ACK     = 8'hFA;
  localparam logic [7:0] KBD_REINIT  = 8'h60;

  typedef enum logic [2:0] {
    ST_RST_LOW,
    ST_RST_SETTLE,
    ST_DRAIN,
    ST_HOLD,
    ST_SEND,
    ST_POST,
    ST_WAIT,
    ST_RUN
  } seq_state_e;

  // Cycles for a delay in microseconds; never below one cycle.
  function automatic int unsigned us_ticks(input int unsigned us, input int unsigned tpu);
    int unsigned t;
    t = us * tpu;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bit 7 marks a key release.
  function automatic logic is_release(input logic [7:0] code);
    return code[7];
  endfunction

endpackage

// File: rtl/kbd_delay_timer.sv
module kbd_delay_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // The phase lasts exactly `limit` cycles, counted from its first cycle.
  assign expired = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/kbd_cmd_fsm.sv
module kbd_cmd_fsm
  import kbd_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned T_RSTLO  = 30,
  parameter int unsigned T_SETTLE = 26,
  parameter int unsigned T_HOLD1  = 100,
  parameter int unsigned T_HOLD2  = 50,
  parameter int unsigned T_POST   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       rx_ready,
  output logic       kbd_rdy,
  output logic       kbd_rst_n,
  output logic       cfg_done,
  output logic       run_mode
);

  seq_state_e state_q, state_d;
  logic       second_q, second_d;
  logic       done_q, done_d;
  logic [CNT_W-1:0] limit;
  logic       phase_over;
  logic       phase_change;

  always_comb begin
    unique case (state_q)
      ST_RST_LOW:    limit = CNT_W'(T_RSTLO);
      ST_RST_SETTLE: limit = CNT_W'(T_SETTLE);
      ST_HOLD:       limit = second_q ? CNT_W'(T_HOLD2) : CNT_W'(T_HOLD1);
      ST_POST:       limit = CNT_W'(T_POST);
      default:       limit = CNT_W'(1);
    endcase
  end

  assign phase_change = (state_d != state_q);

  kbd_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_change),
    .limit   (limit),
    .expired (phase_over)
  );

  always_comb begin
    state_d  = state_q;
    second_d = second_q;
    done_d   = done_q;
    unique case (state_q)
      ST_RST_LOW:    if (phase_over) state_d = ST_RST_SETTLE;
      ST_RST_SETTLE: if (phase_over) state_d = ST_DRAIN;
      ST_DRAIN: if (!rx_valid) begin
        state_d  = ST_HOLD;
        second_d = 1'b0;
      end
      ST_HOLD: if (phase_over) state_d = ST_SEND;
      ST_SEND: if (tx_ready) state_d = ST_POST;
      ST_POST: if (phase_over) state_d = ST_WAIT;
      ST_WAIT: if (rx_valid) begin
        if (rx_data != KBD_ACK) begin
          state_d  = ST_HOLD;
          second_d = 1'b0;
        end else if (!second_q) begin
          state_d  = ST_HOLD;
          second_d = 1'b1;
        end else begin
          state_d = ST_RUN;
          done_d  = 1'b1;
        end
      end
      ST_RUN: if (rx_valid && rx_data == KBD_REINIT) begin
        state_d = ST_DRAIN;
        done_d  = 1'b0;
      end
      default: state_d = ST_RST_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RST_LOW;
      second_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      done_q   <= done_d;
    end
  end

  assign tx_valid  = (state_q == ST_SEND);
  assign tx_data   = second_q ? ARG_INHIBIT : CMD_INHIBIT;
  assign rx_ready  = (state_q == ST_DRAIN) || (state_q == ST_WAIT) || (state_q == ST_RUN);
  assign kbd_rdy   = (state_q == ST_RST_LOW) || (state_q == ST_RST_SETTLE) ||
                     (state_q == ST_DRAIN) || (state_q == ST_HOLD) || (state_q == ST_SEND);
  assign kbd_rst_n = (state_q != ST_RST_LOW);
  assign cfg_done  = done_q;
  assign run_mode  = (state_q == ST_RUN);

  // R10: an offered byte is held until the transmitter takes it
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R4: the handshake line is up whenever a byte is offered
  a_r4_rdy_with_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> kbd_rdy);

  // R1: no command while the keyboard is held in reset
  a_r1_no_cmd_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> kbd_rst_n);

  // R5: after a byte goes out, no response is taken at once and the line drops
  a_r5_post_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !rx_ready && !kbd_rdy);

  // R6: a bad answer sends the sequence back to the first command byte
  a_r6_retry_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && rx_valid && rx_data != KBD_ACK |=> kbd_rdy && tx_data == CMD_INHIBIT && !cfg_done);

endmodule

// File: rtl/kbd_scan_fwd.sv
module kbd_scan_fwd
  import kbd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_mode,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       scan_valid,
  output logic [7:0] scan_code,
  output logic       scan_release
);

  logic       pass_now;
  logic       valid_q;
  logic [7:0] code_q;

  assign pass_now = run_mode && rx_valid && (rx_data != KBD_REINIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= pass_now;
      if (pass_now) code_q <= rx_data;
    end
  end

  assign scan_valid   = valid_q;
  assign scan_code    = code_q;
  assign scan_release = is_release(code_q);

endmodule

// File: rtl/kbd_init_seq.sv
module kbd_init_seq
  import kbd_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_US  = 100,
  parameter int unsigned RST_LOW_US    = 15,
  parameter int unsigned RST_SETTLE_US = 13,
  parameter int unsigned HOLD1_US      = 500000,
  parameter int unsigned HOLD2_US      = 100000,
  parameter int unsigned POST_US       = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       kbd_rdy,
  output logic       kbd_rst_n,
  output logic       cfg_done,
  output logic       scan_valid,
  output logic [7:0] scan_code,
  output logic       scan_release
);

  localparam int unsigned T_RSTLO  = us_ticks(RST_LOW_US, TICKS_PER_US);
  localparam int unsigned T_SETTLE = us_ticks(RST_SETTLE_US, TICKS_PER_US);
  localparam int unsigned T_HOLD1  = us_ticks(HOLD1_US, TICKS_PER_US);
  localparam int unsigned T_HOLD2  = us_ticks(HOLD2_US, TICKS_PER_US);
  localparam int unsigned T_POST   = us_ticks(POST_US, TICKS_PER_US);
  localparam int unsigned T_MAX    = max2(max2(max2(T_RSTLO, T_SETTLE), max2(T_HOLD1, T_HOLD2)), T_POST);
  localparam int unsigned CNT_W    = $clog2(T_MAX + 1);

  logic run_mode;

  kbd_cmd_fsm #(
    .CNT_W(CNT_W), .T_RSTLO(T_RSTLO), .T_SETTLE(T_SETTLE),
    .T_HOLD1(T_HOLD1), .T_HOLD2(T_HOLD2), .T_POST(T_POST)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_ready  (rx_ready),
    .kbd_rdy   (kbd_rdy),
    .kbd_rst_n (kbd_rst_n),
    .cfg_done  (cfg_done),
    .run_mode  (run_mode)
  );

  kbd_scan_fwd u_fwd (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_mode     (run_mode),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .scan_valid   (scan_valid),
    .scan_code    (scan_code),
    .scan_release (scan_release)
  );

  // R7: scan output only once configured
  a_r7_scan_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> cfg_done);

  // R8: a configured byte other than the reinit code comes out one cycle later
  a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && cfg_done && rx_data != KBD_REINIT
    |=> scan_valid && scan_code == $past(rx_data) && scan_release == $past(rx_data[7]));

  // R9: the reinit code is swallowed and drops the done flag
  a_r9_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && cfg_done && rx_data == KBD_REINIT |=> !scan_valid && !cfg_done);

endmodule

// File: tb/kbd_init_seq_tb.sv
module kbd_init_seq_tb;

  localparam int unsigned TPU = 2;
  localparam int unsigned L_RSTLO  = 15 * TPU;
  localparam int unsigned L_SETTLE = 13 * TPU;
  localparam int unsigned L_HOLD1  = 20 * TPU;
  localparam int unsigned L_HOLD2  = 10 * TPU;
  localparam int unsigned L_POST   = 10 * TPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_ready = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, rx_ready, kbd_rdy, kbd_rst_n, cfg_done, scan_valid, scan_release;
  logic [7:0] tx_data, scan_code;

  int checks = 0;
  int failures = 0;
  int stray_scan = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  kbd_init_seq #(
    .TICKS_PER_US(TPU), .RST_LOW_US(15), .RST_SETTLE_US(13),
    .HOLD1_US(20), .HOLD2_US(10), .POST_US(10)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .kbd_rdy(kbd_rdy),
    .kbd_rst_n(kbd_rst_n), .cfg_done(cfg_done), .scan_valid(scan_valid),
    .scan_code(scan_code), .scan_release(scan_release)
  );

  always @(negedge clk) if (rst_n && scan_valid && !cfg_done) stray_scan++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Offer a byte on the receive stream; returns at the negedge after acceptance.
  task automatic send_rx(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Wait for a command byte, optionally stall the transmitter.
  task automatic take_tx(input string req, input logic [7:0] exp, input int stall);
    while (!tx_valid) @(negedge clk);
    chk({req, " cmd byte"}, tx_data, exp);
    chk("R4 rdy high while offered", kbd_rdy, 1'b1);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10 byte held", {tx_valid, tx_data}, {1'b1, exp});
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  // Count quiet cycles after a byte goes out: rdy low, rx_ready low.
  task automatic post_window();
    int n = 0;
    int rdy_bad = 0;
    while (!rx_ready) begin
      if (kbd_rdy) rdy_bad++;
      n++;
      @(negedge clk);
    end
    chk("R5 post-send quiet cycles", n, L_POST);
    chk("R5 rdy low after send", rdy_bad, 0);
  endtask

  // Count cycles with rdy high before the byte is offered.
  task automatic hold_window(input string req, input int exp);
    int n = 0;
    while (!kbd_rdy) @(negedge clk);
    while (!tx_valid) begin
      n++;
      @(negedge clk);
    end
    chk(req, n, exp);
  endtask

  task automatic t_reset();
    rx_valid = 1'b1;
    rx_data  = 8'h11;
    repeat (3) @(negedge clk);
    chk("R1 reset line low in reset", kbd_rst_n, 1'b0);
    chk("R7 done low in reset", cfg_done, 1'b0);
    chk("R7 no scan in reset", scan_valid, 1'b0);
    chk("R1 no command in reset", tx_valid, 1'b0);
  endtask

  task automatic t_reset_pulse();
    int n = 0;
    rst_n = 1'b1;
    while (!kbd_rst_n) begin
      if (tx_valid || rx_ready) n += 1000;
      n++;
      @(negedge clk);
    end
    chk("R1 reset pulse width", n, L_RSTLO);
    n = 0;
    while (!rx_ready) begin
      n++;
      @(negedge clk);
    end
    chk("R1 settle time", n, L_SETTLE);
  endtask

  task automatic t_drain(input logic [7:0] a, input logic [7:0] b);
    send_rx(a);
    chk("R2 stale byte not forwarded", scan_valid, 1'b0);
    send_rx(b);
    chk("R2 second stale byte not forwarded", scan_valid, 1'b0);
  endtask

  task automatic t_full_config_with_retries();
    take_tx("R3 first", 8'h9C, 3);
    post_window();
    send_rx(8'hFE);
    chk("R6 done low after bad answer", cfg_done, 1'b0);
    hold_window("R6 R4 retry hold before 0x9C", L_HOLD1);
    take_tx("R6 retry restarts", 8'h9C, 0);
    post_window();
    send_rx(8'hFA);
    hold_window("R4 hold before 0x70", L_HOLD2);
    take_tx("R3 second", 8'h70, 2);
    post_window();
    send_rx(8'h00);
    hold_window("R6 R4 hold after bad 2nd answer", L_HOLD1);
    take_tx("R6 bad 2nd answer restarts", 8'h9C, 0);
    post_window();
    send_rx(8'hFA);
    chk("R7 done low after one ack", cfg_done, 1'b0);
    take_tx("R3 second again", 8'h70, 0);
    post_window();
    send_rx(8'hFA);
    chk("R7 done after both acks", cfg_done, 1'b1);
  endtask

  task automatic t_forward();
    send_rx(8'h1A);
    chk("R8 press strobe", {scan_valid, scan_code, scan_release}, {1'b1, 8'h1A, 1'b0});
    send_rx(8'h9A);
    chk("R8 release strobe", {scan_valid, scan_code, scan_release}, {1'b1, 8'h9A, 1'b1});
    @(negedge clk);
    chk("R8 strobe one cycle", scan_valid, 1'b0);
  endtask

  task automatic t_reinit();
    send_rx(8'h60);
    chk("R9 reinit not forwarded", scan_valid, 1'b0);
    chk("R9 done cleared", cfg_done, 1'b0);
    chk("R9 drain runs first", rx_ready, 1'b1);
    send_rx(8'h33);
    chk("R2 R9 drained byte not forwarded", scan_valid, 1'b0);
    take_tx("R9 rerun starts", 8'h9C, 0);
    post_window();
    send_rx(8'hFA);
    take_tx("R9 rerun second", 8'h70, 0);
    post_window();
    send_rx(8'hFA);
    chk("R9 done after rerun", cfg_done, 1'b1);
    send_rx(8'h05);
    chk("R8 forward after rerun", {scan_valid, scan_code}, {1'b1, 8'h05});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_reset_pulse();
    t_drain(8'h11, 8'h22);
    t_full_config_with_retries();
    t_forward();
    t_reinit();
    chk("R7 no scan while unconfigured", stray_scan, 0);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

endmodule